// File: doc/BRIEF.md
# Trigger-to-Sample Fine Interval Counter

This block measures where a trigger falls between two sample-clock edges, so that each captured record can be placed against earlier records with a resolution finer than one sample period. When a trigger is accepted, the block raises a gate output. The gate stays high until the next sample-clock strobe. An external time-stretcher integrates this gate and reports completion much later, typically after about five hundred times the gate width.

The block counts reference-clock cycles from the accepted trigger until the stretcher reports completion. It then freezes the count in an output register and raises a valid flag. A host reads the count and drops the flag with a clear strobe. If completion never arrives, the counter stops at its largest value rather than wrapping. In that case a timeout flag marks the result as unusable.

All inputs are sampled on the reference clock. The sample-clock input is a one-cycle enable marking each sample edge.

Top module: `trig_interp_counter`

## Requirements
- R1: A trigger sampled high while no measurement runs, no result is held and clear is low is accepted, and `gate_o` is high from the following cycle.
- R2: The gate stays high until the first `samp_en_i` strobe sampled after the accepting edge, and it goes low in the cycle after that strobe. A strobe coinciding with the trigger is not that strobe, so the gate lasts at least one cycle and is exactly as many cycles wide as the trigger-to-sample gap.
- R3: The stored count equals the number of reference-clock edges from the accepting edge up to and including the edge that samples `stretch_done_i` high after the gate has ended. A completion pulse seen while the gate is still high is ignored.
- R4: `valid_o` rises in the cycle after the counter stops and holds, together with an unchanged `count_o`, until `clear_i` is sampled high.
- R5: A trigger sampled while a measurement runs or while `valid_o` is high has no effect on the gate, the count or the flags.
- R6: If the running count reaches 2^CNT_W-1 (65535 by default) without completion, the measurement ends at the next edge with `count_o` = 2^CNT_W-1 and both `valid_o` and `timeout_o` high. The count never wraps.
- R7: `clear_i` sampled high drops `valid_o` and `timeout_o`, aborts any running measurement and forces the gate low from the next cycle. `count_o` keeps its last value.
- R8: After reset, `gate_o`, `valid_o` and `timeout_o` are low and `count_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the sample-rate oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger event, sampled each cycle |
| samp_en_i | input | 1 | One-cycle strobe marking a sample-clock edge |
| stretch_done_i | input | 1 | Completion report from the external stretcher |
| clear_i | input | 1 | Host clear of the held result; also aborts a measurement |
| gate_o | output | 1 | Trigger-to-sample gate sent to the stretcher |
| count_o | output | CNT_W | Stored fine trigger position in reference cycles |
| valid_o | output | 1 | A result is held in `count_o` |
| timeout_o | output | 1 | The held result ended by saturation |

## Verification
The in-line properties watch, on every cycle, the following rules:
- the gate rises only after a trigger and falls one cycle after a sample strobe;
- a clear empties the flags and the gate;
- a held result does not move;
- a timeout always comes with a full-scale, valid count;
- the running counter never leaves its maximum once it gets there.

Some behaviour can only be shown by the bench's scenarios, each with a modelled stretcher:
- the exact gate width and final count across different gaps and stretch factors;
- the refusal of retriggers, coincident strobes and early completions;
- the full saturation run to 65535.

// File: rtl/ticnt_pkg.sv
package ticnt_pkg;
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_GATE    = 2'd1,
      PH_STRETCH = 2'd2
   } phase_t;
endpackage

// File: rtl/ticnt_phase_fsm.sv
module ticnt_phase_fsm
   import ticnt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   trig_i,
   input  logic   samp_en_i,
   input  logic   done_i,
   input  logic   clear_i,
   input  logic   held_i,
   input  logic   sat_i,
   output phase_t phase_o,
   output logic   start_o,
   output logic   busy_o,
   output logic   finish_o,
   output logic   tmo_o,
   output logic   gate_o
);
   phase_t phase_q, phase_d;
   logic   done_ok;

   assign busy_o  = (phase_q != PH_IDLE);
   assign done_ok = (phase_q == PH_STRETCH) && done_i;
   assign start_o = (phase_q == PH_IDLE) && trig_i && !held_i && !clear_i;
   assign finish_o = !clear_i && (done_ok || (busy_o && sat_i));
   assign tmo_o   = finish_o && !done_ok;

   always_comb begin
      phase_d = phase_q;
      if (clear_i) begin
         phase_d = PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_IDLE:    if (start_o) phase_d = PH_GATE;
            PH_GATE:    if (finish_o) phase_d = PH_IDLE;
                        else if (samp_en_i) phase_d = PH_STRETCH;
            PH_STRETCH: if (finish_o) phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         gate_o  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         gate_o  <= (phase_d == PH_GATE);
      end
   end

   assign phase_o = phase_q;

   // R1: a gate only opens after an accepted trigger
   p_gate_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $past(trig_i) && !$past(clear_i));
   // R2: a sample strobe during the gate closes it one cycle later
   p_gate_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o && samp_en_i |=> !gate_o);
   // R7: clear forces the gate low
   p_clear_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !gate_o);
endmodule

// File: rtl/ticnt_sat_counter.sv
module ticnt_sat_counter #(
   parameter int CNT_W     = 16,
   parameter int SAT_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             en_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] inc_o,
   output logic             at_max_o
);
   logic [CNT_W-1:0] cnt_q;

   if (SAT_STYLE == 0) begin : g_cmp
      assign at_max_o = &cnt_q;
      assign inc_o    = at_max_o ? cnt_q : cnt_q + 1'b1;
   end else begin : g_carry
      logic [CNT_W:0] sum;
      assign sum      = {1'b0, cnt_q} + 1'b1;
      assign at_max_o = sum[CNT_W];
      assign inc_o    = sum[CNT_W] ? cnt_q : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (start_i) cnt_q <= '0;
      else if (en_i)    cnt_q <= inc_o;
   end

   assign cnt_o = cnt_q;

   // R6: once at full scale, the running count stays there
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && !start_i && at_max_o |=> at_max_o);
endmodule

// File: rtl/ticnt_result.sv
module ticnt_result #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             finish_i,
   input  logic             tmo_i,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] value_i,
   output logic [CNT_W-1:0] count_o,
   output logic             valid_o,
   output logic             timeout_o
);
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o   <= '0;
         valid_o   <= 1'b0;
         timeout_o <= 1'b0;
      end else if (clear_i) begin
         valid_o   <= 1'b0;
         timeout_o <= 1'b0;
      end else if (finish_i) begin
         count_o   <= value_i;
         valid_o   <= 1'b1;
         timeout_o <= tmo_i;
      end
   end

   // R4: a held result does not change until cleared
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !clear_i |=> valid_o && $stable(count_o));
   // R6: a timeout always carries a valid full-scale count
   p_tmo_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> valid_o && count_o == FULL);
   // R7: clear empties the flags
   p_clear_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !valid_o && !timeout_o);
endmodule

// File: rtl/trig_interp_counter.sv
module trig_interp_counter #(
   parameter int CNT_W     = 16,
   parameter int SAT_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             samp_en_i,
   input  logic             stretch_done_i,
   input  logic             clear_i,
   output logic             gate_o,
   output logic [CNT_W-1:0] count_o,
   output logic             valid_o,
   output logic             timeout_o
);
   import ticnt_pkg::*;

   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
      $error("trig_interp_counter: CNT_W must be within 4..32");
   end
   if (SAT_STYLE != 0 && SAT_STYLE != 1) begin : g_bad_style
      $error("trig_interp_counter: SAT_STYLE must be 0 or 1");
   end

   phase_t           phase;
   logic             start, busy, finish, tmo, at_max;
   logic [CNT_W-1:0] cnt, cnt_inc;

   ticnt_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_i),
      .samp_en_i (samp_en_i),
      .done_i    (stretch_done_i),
      .clear_i   (clear_i),
      .held_i    (valid_o),
      .sat_i     (at_max),
      .phase_o   (phase),
      .start_o   (start),
      .busy_o    (busy),
      .finish_o  (finish),
      .tmo_o     (tmo),
      .gate_o    (gate_o)
   );

   ticnt_sat_counter #(.CNT_W(CNT_W), .SAT_STYLE(SAT_STYLE)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .en_i     (busy),
      .cnt_o    (cnt),
      .inc_o    (cnt_inc),
      .at_max_o (at_max)
   );

   ticnt_result #(.CNT_W(CNT_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .finish_i  (finish),
      .tmo_i     (tmo),
      .clear_i   (clear_i),
      .value_i   (cnt_inc),
      .count_o   (count_o),
      .valid_o   (valid_o),
      .timeout_o (timeout_o)
   );

   // R5: no gate while a result is held
   p_no_gate_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !gate_o);
   // R3: a result appears only when a running measurement ends
   p_valid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(phase != PH_IDLE));
   // R5: the counter is not restarted while running
   p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !finish && !clear_i |=> cnt != '0);
endmodule

// File: tb/tb_trig_interp_counter.sv
module tb_trig_interp_counter;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 16;
   localparam int FULL = (1 << W) - 1;
   localparam int NVEC = 6;
   // fields: gap, stretch factor, retrigger during gate, strobe with trigger
   localparam int VEC [NVEC][4] = '{
      '{1, 3, 0, 1}, '{2, 5, 1, 0}, '{7, 4, 1, 0},
      '{13, 2, 0, 1}, '{4, 10, 0, 0}, '{30, 7, 1, 1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic trig = 1'b0, samp = 1'b0, done = 1'b0, clr = 1'b0;
   logic gate, valid, tmo;
   logic [W-1:0] count;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_interp_counter #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .samp_en_i(samp),
      .stretch_done_i(done), .clear_i(clr), .gate_o(gate),
      .count_o(count), .valid_o(valid), .timeout_o(tmo));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   // trigger, sample strobe after gap cycles, stretcher model answers after k*gap
   task automatic measure(input int gap, input int k, input bit retrig,
                          input bit coinc, input bit early_done, output int gw);
      gw = 0;
      @(negedge clk); trig = 1'b1; samp = coinc;
      for (int j = 1; j <= gap; j++) begin
         @(negedge clk);
         if (gate) gw++;
         trig = (j == 1) && retrig;
         samp = (j == gap);
         done = early_done && (j == 1);
      end
      for (int j = 1; j <= k*gap; j++) begin
         @(negedge clk);
         if (gate) gw++;
         trig = 1'b0; samp = 1'b0;
         done = (j == k*gap);
      end
      @(negedge clk); done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int gw;
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      chk(!gate && !valid && !tmo, "R8 flags after reset", {gate, valid, tmo}, 0);
      chk(count == 0, "R8 count after reset", count, 0);

      // R1 R2 R3 R4 R5: table-driven measurements
      for (int i = 0; i < NVEC; i++) begin
         measure(VEC[i][0], VEC[i][1], VEC[i][2] != 0, VEC[i][3] != 0, 1'b0, gw);
         chk(gw == VEC[i][0], "R1/R2 gate width", gw, VEC[i][0]);
         chk(valid && !tmo, "R4 valid after done", {valid, tmo}, 2);
         chk(count == VEC[i][0]*(VEC[i][1]+1), "R3 count", count,
             VEC[i][0]*(VEC[i][1]+1));
         // R5: trigger while result held
         held = count;
         @(negedge clk); trig = 1'b1;
         @(negedge clk); trig = 1'b0;
         chk(!gate, "R5 no gate while held", gate, 0);
         @(negedge clk);
         chk(valid && count == held, "R4 result held", count, held);
         do_clear();
         chk(!valid, "R7 clear drops valid", valid, 0);
      end

      // R3: early completion during the gate is ignored
      measure(5, 3, 1'b0, 1'b0, 1'b1, gw);
      chk(count == 20 && valid, "R3 early done ignored", count, 20);
      do_clear();

      // R7: clear aborts a running measurement, count kept
      held = count;
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk(!gate, "R7 gate low after clear", gate, 0);
      samp = 1'b1; @(negedge clk); samp = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1; @(negedge clk); done = 1'b0;
      @(negedge clk);
      chk(!valid && count == held, "R7 aborted no result", count, held);

      // R6: stretcher never answers
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      @(negedge clk); samp = 1'b1;
      @(negedge clk); samp = 1'b0;
      repeat (FULL - 10) @(negedge clk);
      chk(!valid, "R6 still running before full scale", valid, 0);
      repeat (40) @(negedge clk);
      chk(valid && tmo, "R6 timeout flags", {valid, tmo}, 3);
      chk(count == FULL, "R6 saturated count", count, FULL);
      do_clear();
      chk(!tmo && !valid, "R7 clear drops timeout", {valid, tmo}, 0);
      chk(count == FULL, "R7 count kept after clear", count, FULL);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule